// File: doc/BRIEF.md
# Debug Command Frame Decoder

This block sits behind the bit-level receiver of a debug line and turns a stream of already assembled bytes into single write requests. The first byte of each frame is an opcode; the low bits of many opcodes carry a field (an access size or a register number), and the opcode decides how many further bytes follow. Multi-byte address and data fields arrive most significant byte first. Once the last byte of a frame is in, the block raises exactly one request strobe for one cycle. The strobe goes to one of six destinations: a memory write port, a CPU register port, a debug-register port, a top-byte write for three debug status/control registers, a program-counter capture, or a resume.

Each command belongs to one of three classes: always available, non-intrusive, or needing the processor halted in background mode. A background-only command that arrives while the processor runs still has its data bytes consumed, so framing stays intact, but it is dropped and a sticky error flag is set. The flag is returned, and then cleared, by the status byte of a memory write-with-status. When acknowledge mode is on, commands marked for it give a one-cycle acknowledge pulse as they complete.

Top module: `dbgf_decoder`

## Requirements
- R1: After reset all strobes (`req_mem`, `req_cpu`, `req_dbg`, `req_hdr`, `pc_capture`, `resume`, `ack_pulse`, `stat_valid`) are low and `stat_byte`, `acc_addr`, `acc_wdata` are zero.
- R2: Opcodes 0x10, 0x14 and 0x18 (0x10 + 4*size; size 0 byte, 1 16-bit, 2 32-bit) take a 3-byte address and 1, 2 or 4 data bytes, MSB first. In the cycle after the last byte, `req_mem` is high for one cycle with `acc_addr`, zero-extended `acc_wdata` and `acc_size`. This works whether or not the processor is halted.
- R3: Opcodes 0x11, 0x15 and 0x19 behave as in R2 but never pulse `ack_pulse`. They also pulse `stat_valid` with `stat_byte` = {error flag, 7'b0}, and the error flag is cleared when reported.
- R4: Size code 3 (opcodes 0x1C, 0x1D) and any opcode not listed here is illegal: no strobe, no data bytes consumed, and the error flag is set.
- R5: Opcode 0x40+n (n in 0..63) writes CPU general register n and opcode 0xC0+n writes CPU control register n. Each takes 4 data bytes and, if `cpu_halted`, pulses `req_cpu` with `reg_num`=n, `cpu_ctrl_sel`=0 or 1 and `acc_wdata`.
- R6: A CPU register write received while `cpu_halted` is low still consumes its 4 data bytes, gives no strobe and no acknowledge, and sets the error flag.
- R7: Opcode 0x80+n takes 4 data bytes and pulses `req_dbg` with `reg_num`=n regardless of `cpu_halted`.
- R8: Opcodes 0x0D, 0x0E and 0x0F take one data byte and pulse `req_hdr` with `hdr_sel` = opcode bits [1:0] and the byte in `acc_wdata[7:0]`, never with an acknowledge.
- R9: Opcode 0x01 takes no data and pulses `pc_capture` one cycle after it is received.
- R10: Opcode 0x0C takes no data. It pulses `resume` if `cpu_halted` is high, and otherwise has no effect and no acknowledge.
- R11: `ack_pulse` rises together with the request strobe of an executed R2, R5, R7 or R9 command only when `ack_mode` was high with the last byte; it never rises otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | rx_byte holds a new byte this cycle |
| cpu_halted | input | 1 | Processor is halted in background mode |
| ack_mode | input | 1 | Acknowledge mode enabled |
| req_mem | output | 1 | Memory write request strobe |
| req_cpu | output | 1 | CPU register write request strobe |
| req_dbg | output | 1 | Debug register write request strobe |
| req_hdr | output | 1 | Debug register top-byte write strobe |
| pc_capture | output | 1 | Capture program counter into trace |
| resume | output | 1 | Resume processor |
| acc_addr | output | ADDR_W | Memory address |
| acc_wdata | output | DATA_W | Write data (zero-extended) |
| acc_size | output | 2 | Memory access size code |
| reg_num | output | REG_W | Register number |
| cpu_ctrl_sel | output | 1 | 1 selects CPU control register, 0 general register |
| hdr_sel | output | 2 | Which status/control register top byte |
| ack_pulse | output | 1 | Handshake acknowledge pulse |
| stat_valid | output | 1 | Status byte valid strobe |
| stat_byte | output | 8 | Status byte, bit 7 is the error flag |

## Verification
The hardest state to reach is a dropped background-only command, because it leaves nothing visible at the ports when it happens. The bench sends a CPU register write with the processor running and follows it at once with a debug-register write. If that second write decodes with the right register and data, the dropped frame consumed exactly four bytes. A memory write-with-status then brings the hidden error flag out through the status byte, and a second one shows that the flag was cleared.

// File: rtl/dbgf_pkg.sv
package dbgf_pkg;
    typedef enum logic [2:0] {
        K_ILL,
        K_MEM,
        K_CPU,
        K_DBG,
        K_HDR,
        K_PC,
        K_GO
    } kind_e;

    localparam logic [1:0] SZ_ILLEGAL = 2'd3;
endpackage

// File: rtl/dbgf_opdec.sv
module dbgf_opdec
    import dbgf_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int DATA_BYTES = 4,
    parameter int CNT_W      = 3
) (
    input  logic [7:0]       op,
    output kind_e            kind,
    output logic [CNT_W-1:0] nbytes,
    output logic [1:0]       size,
    output logic             with_stat,
    output logic             need_halt,
    output logic             ackable
);
    always_comb begin
        kind      = K_ILL;
        nbytes    = '0;
        size      = op[3:2];
        with_stat = 1'b0;
        need_halt = 1'b0;
        ackable   = 1'b0;
        case (op[7:6])
            2'b01, 2'b11: begin
                kind      = K_CPU;
                nbytes    = CNT_W'(DATA_BYTES);
                need_halt = 1'b1;
                ackable   = 1'b1;
            end
            2'b10: begin
                kind    = K_DBG;
                nbytes  = CNT_W'(DATA_BYTES);
                ackable = 1'b1;
            end
            default: begin
                if (op[5:4] == 2'b01 && !op[1] && op[3:2] != SZ_ILLEGAL) begin
                    kind      = K_MEM;
                    nbytes    = CNT_W'(ADDR_BYTES + (1 << op[3:2]));
                    with_stat = op[0];
                    ackable   = !op[0];
                end else if (op[5:0] == 6'h0D || op[5:0] == 6'h0E || op[5:0] == 6'h0F) begin
                    kind   = K_HDR;
                    nbytes = CNT_W'(1);
                end else if (op[5:0] == 6'h01) begin
                    kind    = K_PC;
                    ackable = 1'b1;
                end else if (op[5:0] == 6'h0C) begin
                    kind = K_GO;
                end
            end
        endcase
    end
endmodule

// File: rtl/dbgf_accum.sv
module dbgf_accum #(
    parameter int W = 56
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic [7:0]   din,
    output logic [W-1:0] nxt
);
    logic [W-9:0] sh_d, sh_q;

    assign nxt = {sh_q, din};

    always_comb begin
        sh_d = sh_q;
        if (clr)
            sh_d = '0;
        else if (shift)
            sh_d = nxt[W-9:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/dbgf_decoder.sv
module dbgf_decoder
    import dbgf_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int REG_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        rx_byte,
    input  logic              rx_valid,
    input  logic              cpu_halted,
    input  logic              ack_mode,
    output logic              req_mem,
    output logic              req_cpu,
    output logic              req_dbg,
    output logic              req_hdr,
    output logic              pc_capture,
    output logic              resume,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_wdata,
    output logic [1:0]        acc_size,
    output logic [REG_W-1:0]  reg_num,
    output logic              cpu_ctrl_sel,
    output logic [1:0]        hdr_sel,
    output logic              ack_pulse,
    output logic              stat_valid,
    output logic [7:0]        stat_byte
);
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int DATA_BYTES = DATA_W / 8;
    localparam int FULL_W     = ADDR_W + DATA_W;
    localparam int CNT_W      = $clog2(ADDR_BYTES + DATA_BYTES + 1);

    typedef struct packed {
        logic              busy;
        logic [7:0]        op;
        logic [CNT_W-1:0]  cnt;
        logic              err;
        logic              req_mem;
        logic              req_cpu;
        logic              req_dbg;
        logic              req_hdr;
        logic              pc_cap;
        logic              go;
        logic              ack;
        logic              stat_v;
        logic [7:0]        stat;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [1:0]        size;
        logic [REG_W-1:0]  regn;
        logic              ctrl;
        logic [1:0]        hsel;
    } st_t;

    st_t s_d, s_q;

    logic [7:0]       op_cur;
    kind_e            kind;
    logic [CNT_W-1:0] nbytes;
    logic [1:0]       dsize;
    logic             with_stat, need_halt, ackable;
    logic [FULL_W-1:0] full;
    logic             last;

    assign op_cur = s_q.busy ? s_q.op : rx_byte;

    dbgf_opdec #(
        .ADDR_BYTES(ADDR_BYTES),
        .DATA_BYTES(DATA_BYTES),
        .CNT_W     (CNT_W)
    ) u_dec (
        .op       (op_cur),
        .kind     (kind),
        .nbytes   (nbytes),
        .size     (dsize),
        .with_stat(with_stat),
        .need_halt(need_halt),
        .ackable  (ackable)
    );

    dbgf_accum #(.W(FULL_W)) u_acc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (rx_valid && !s_q.busy),
        .shift(rx_valid && s_q.busy),
        .din  (rx_byte),
        .nxt  (full)
    );

    assign last = rx_valid && (s_q.busy ? (s_q.cnt == CNT_W'(1)) : (nbytes == '0));

    always_comb begin
        s_d         = s_q;
        s_d.req_mem = 1'b0;
        s_d.req_cpu = 1'b0;
        s_d.req_dbg = 1'b0;
        s_d.req_hdr = 1'b0;
        s_d.pc_cap  = 1'b0;
        s_d.go      = 1'b0;
        s_d.ack     = 1'b0;
        s_d.stat_v  = 1'b0;

        if (rx_valid && !s_q.busy && nbytes != '0) begin
            s_d.busy = 1'b1;
            s_d.op   = rx_byte;
            s_d.cnt  = nbytes;
        end else if (rx_valid && s_q.busy && !last) begin
            s_d.cnt = s_q.cnt - CNT_W'(1);
        end

        if (last) begin
            s_d.busy = 1'b0;
            case (kind)
                K_MEM: begin
                    s_d.req_mem = 1'b1;
                    s_d.size    = dsize;
                    s_d.ack     = ackable && ack_mode;
                    case (dsize)
                        2'd0: begin
                            s_d.addr  = full[8 +: ADDR_W];
                            s_d.wdata = {{(DATA_W-8){1'b0}}, full[7:0]};
                        end
                        2'd1: begin
                            s_d.addr  = full[16 +: ADDR_W];
                            s_d.wdata = {{(DATA_W-16){1'b0}}, full[15:0]};
                        end
                        default: begin
                            s_d.addr  = full[DATA_W +: ADDR_W];
                            s_d.wdata = full[DATA_W-1:0];
                        end
                    endcase
                    if (with_stat) begin
                        s_d.stat_v = 1'b1;
                        s_d.stat   = {s_q.err, 7'b0};
                        s_d.err    = 1'b0;
                    end
                end
                K_CPU: begin
                    if (!need_halt || cpu_halted) begin
                        s_d.req_cpu = 1'b1;
                        s_d.regn    = op_cur[REG_W-1:0];
                        s_d.ctrl    = op_cur[7];
                        s_d.wdata   = full[DATA_W-1:0];
                        s_d.ack     = ackable && ack_mode;
                    end else begin
                        s_d.err = 1'b1;
                    end
                end
                K_DBG: begin
                    s_d.req_dbg = 1'b1;
                    s_d.regn    = op_cur[REG_W-1:0];
                    s_d.wdata   = full[DATA_W-1:0];
                    s_d.ack     = ackable && ack_mode;
                end
                K_HDR: begin
                    s_d.req_hdr = 1'b1;
                    s_d.hsel    = op_cur[1:0];
                    s_d.wdata   = {{(DATA_W-8){1'b0}}, full[7:0]};
                end
                K_PC: begin
                    s_d.pc_cap = 1'b1;
                    s_d.ack    = ackable && ack_mode;
                end
                K_GO: begin
                    s_d.go = cpu_halted;
                end
                default: begin
                    s_d.err = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_mem      = s_q.req_mem;
    assign req_cpu      = s_q.req_cpu;
    assign req_dbg      = s_q.req_dbg;
    assign req_hdr      = s_q.req_hdr;
    assign pc_capture   = s_q.pc_cap;
    assign resume       = s_q.go;
    assign acc_addr     = s_q.addr;
    assign acc_wdata    = s_q.wdata;
    assign acc_size     = s_q.size;
    assign reg_num      = s_q.regn;
    assign cpu_ctrl_sel = s_q.ctrl;
    assign hdr_sel      = s_q.hsel;
    assign ack_pulse    = s_q.ack;
    assign stat_valid   = s_q.stat_v;
    assign stat_byte    = s_q.stat;
endmodule

// File: rtl/dbgf_checker.sv
module dbgf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_halted,
    input logic       ack_mode,
    input logic       req_mem,
    input logic       req_cpu,
    input logic       req_dbg,
    input logic       req_hdr,
    input logic       pc_capture,
    input logic       resume,
    input logic [1:0] acc_size,
    input logic       ack_pulse,
    input logic       stat_valid
);
    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_mem, req_cpu, req_dbg, req_hdr, pc_capture, resume})); // R2
    AST_MEM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_mem |=> !req_mem); // R2
    AST_STATUS_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> (req_mem && !ack_pulse)); // R3
    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        req_mem |-> (acc_size != 2'd3)); // R4
    AST_CPU_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        req_cpu |-> $past(cpu_halted)); // R5
    AST_HDR_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        req_hdr |-> !ack_pulse); // R8
    AST_RESUME_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> ($past(cpu_halted) && !ack_pulse)); // R10
    AST_ACK_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_pulse |-> ($past(ack_mode) && (req_mem || req_cpu || req_dbg || pc_capture))); // R11
endmodule

bind dbgf_decoder dbgf_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_halted(cpu_halted),
    .ack_mode  (ack_mode),
    .req_mem   (req_mem),
    .req_cpu   (req_cpu),
    .req_dbg   (req_dbg),
    .req_hdr   (req_hdr),
    .pc_capture(pc_capture),
    .resume    (resume),
    .acc_size  (acc_size),
    .ack_pulse (ack_pulse),
    .stat_valid(stat_valid)
);

// File: tb/sim_dbgf_decoder.sv
module sim_dbgf_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0;
    logic        cpu_halted = 1'b0;
    logic        ack_mode = 1'b0;
    logic        req_mem, req_cpu, req_dbg, req_hdr, pc_capture, resume;
    logic [23:0] acc_addr;
    logic [31:0] acc_wdata;
    logic [1:0]  acc_size;
    logic [5:0]  reg_num;
    logic        cpu_ctrl_sel;
    logic [1:0]  hdr_sel;
    logic        ack_pulse, stat_valid;
    logic [7:0]  stat_byte;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dbgf_decoder u0 (.*);

    // strobe vector: mem cpu dbg hdr pc resume ack stat
    function automatic logic [7:0] strobes();
        return {req_mem, req_cpu, req_dbg, req_hdr, pc_capture, resume, ack_pulse, stat_valid};
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(logic [7:0] b);
        @(negedge clk);
        rx_byte  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 strobes", strobes(), 8'h00);
        check("R1 stat", stat_byte, 8'h00);
        check("R1 addr/data", {acc_addr, acc_wdata}, 56'h0);
    endtask

    task automatic t_mem();
        ack_mode   = 1'b1;
        cpu_halted = 1'b0;
        send(8'h10); send(8'h12); send(8'h34); send(8'h56); send(8'hA5);
        check("R2 byte strobes+R11 ack", strobes(), 8'b1000_0010);
        check("R2 byte addr", acc_addr, 24'h123456);
        check("R2 byte data", acc_wdata, 32'hA5);
        check("R2 byte size", acc_size, 2'd0);
        idle();
        check("R2 single cycle", strobes(), 8'h00);
        send(8'h14); send(8'h00); send(8'h00); send(8'h10); send(8'hBE); send(8'hEF);
        check("R2 word addr", acc_addr, 24'h000010);
        check("R2 word data", acc_wdata, 32'hBEEF);
        check("R2 word size", acc_size, 2'd1);
        ack_mode = 1'b0;
        send(8'h18); send(8'hAB); send(8'hCD); send(8'hEF);
        send(8'h01); send(8'h02); send(8'h03); send(8'h04);
        check("R11 long no ack", strobes(), 8'b1000_0000);
        check("R2 long addr", acc_addr, 24'hABCDEF);
        check("R2 long data", acc_wdata, 32'h01020304);
        check("R2 long size", acc_size, 2'd2);
    endtask

    task automatic t_ws();
        ack_mode = 1'b1;
        send(8'h19); send(8'h00); send(8'h00); send(8'h20);
        send(8'h11); send(8'h22); send(8'h33); send(8'h44);
        check("R3 strobes no ack", strobes(), 8'b1000_0001);
        check("R3 status clean", stat_byte, 8'h00);
        check("R3 data", acc_wdata, 32'h11223344);
    endtask

    task automatic t_illegal();
        send(8'h1C);
        check("R4 no strobe", strobes(), 8'h00);
        send(8'h11); send(8'h00); send(8'h00); send(8'h01); send(8'h5A);
        check("R4 framing after illegal", {acc_addr, acc_wdata[7:0]}, 32'h0000015A);
        check("R4 error reported", stat_byte, 8'h80);
        send(8'h11); send(8'h00); send(8'h00); send(8'h02); send(8'h5B);
        check("R3 error cleared", stat_byte, 8'h00);
    endtask

    task automatic t_cpu();
        cpu_halted = 1'b1;
        ack_mode   = 1'b1;
        send(8'h43); send(8'hDE); send(8'hAD); send(8'hBE); send(8'hEF);
        check("R5 gp strobes", strobes(), 8'b0100_0010);
        check("R5 gp reg", {cpu_ctrl_sel, reg_num}, {1'b0, 6'd3});
        check("R5 gp data", acc_wdata, 32'hDEADBEEF);
        send(8'hC5); send(8'h00); send(8'h00); send(8'h00); send(8'h07);
        check("R5 ctrl reg", {cpu_ctrl_sel, reg_num}, {1'b1, 6'd5});
        check("R5 ctrl data", acc_wdata, 32'h7);
    endtask

    task automatic t_cpu_running();
        cpu_halted = 1'b0;
        ack_mode   = 1'b1;
        send(8'h47); send(8'h01); send(8'h02); send(8'h03); send(8'h04);
        check("R6 dropped", strobes(), 8'h00);
        send(8'h82); send(8'hCA); send(8'hFE); send(8'hBA); send(8'hBE);
        check("R7 dbg strobes", strobes(), 8'b0010_0010);
        check("R7 dbg reg", reg_num, 6'd2);
        check("R7 dbg data", acc_wdata, 32'hCAFEBABE);
        send(8'h11); send(8'h00); send(8'h00); send(8'h03); send(8'h00);
        check("R6 error reported", stat_byte, 8'h80);
    endtask

    task automatic t_hdr();
        ack_mode = 1'b1;
        send(8'h0E); send(8'h9C);
        check("R8 strobes no ack", strobes(), 8'b0001_0000);
        check("R8 sel", hdr_sel, 2'd2);
        check("R8 data", acc_wdata, 32'h9C);
        send(8'h0D); send(8'h11);
        check("R8 sel low", hdr_sel, 2'd1);
    endtask

    task automatic t_pc();
        ack_mode = 1'b1;
        send(8'h01);
        check("R9 pc with ack", strobes(), 8'b0000_1010);
        ack_mode = 1'b0;
        send(8'h01);
        check("R11 pc no ack", strobes(), 8'b0000_1000);
    endtask

    task automatic t_go();
        ack_mode   = 1'b1;
        cpu_halted = 1'b1;
        send(8'h0C);
        check("R10 resume halted", strobes(), 8'b0000_0100);
        cpu_halted = 1'b0;
        send(8'h0C);
        check("R10 resume running ignored", strobes(), 8'h00);
        send(8'h11); send(8'h00); send(8'h00); send(8'h04); send(8'h00);
        check("R10 no error", stat_byte, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle();
        t_reset();
        t_mem();
        t_ws();
        t_illegal();
        t_cpu();
        t_cpu_running();
        t_hdr();
        t_pc();
        t_go();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule